// File: doc/BRIEF.md
# Packet I2C Controller Interrupt and FIFO-Control Register Block

This block is the software-facing register file of a packet-mode I2C master. It collects event pulses from the bus engine into a sticky interrupt status register. It derives FIFO service requests from the occupancy counts of the transmit and receive word FIFOs and programmable trigger levels. It gates status with an enable mask onto a single registered interrupt line. It also issues one-cycle flush requests to the two FIFOs.

Software reaches the registers through a simple strobe-based port. A write takes effect on the clock edge where `reg_wr` is high. A read strobe loads `reg_rdata` on its edge. A configuration word and a clock divisor word are held as plain storage. A build-time parameter selects an alternate register layout in which every offset is moved. Offsets at or above 0x050 move up by 0x10, and lower ones move up by 0x40. The FIFO storage and the bus engine live outside the block.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After a synchronous reset, status, enable mask, FIFO control, configuration, divisor, `irq`, `tx_flush` and `rx_flush` are all zero.
- R2: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. A set event in the same cycle wins over the clear.
- R3: A write to the transmit FIFO word (offset 0x050) while `tx_free` is 0 sets status bit 5. The same write with a free slot leaves bit 5 clear.
- R4: A read of the receive FIFO word (offset 0x054) while `rx_fill` is 0 sets status bit 4. The same read with data present leaves bit 4 clear.
- R5: Pulses on `ev_pkt_done`, `ev_all_done`, `ev_nack` and `ev_arb_lost` latch status bits 7, 6, 3 and 2. These bits stay set until cleared.
- R6: Status bit 1 tracks `tx_free` > TX trigger level, and bit 0 tracks `rx_fill` > RX trigger level. Both update on the next edge, and writing 1 to them does not clear them while the condition holds.
- R7: `irq` is high exactly when some status bit and its mask bit (offset 0x064) are both 1. It changes on the same edge as the status bit.
- R8: In FIFO control (offset 0x05C), bit 1 requests a TX flush and bit 0 an RX flush. Each such bit drives its flush output for one cycle, reads back as 1 only in the cycle after the write, then clears itself. The TX trigger in bits 7:5 and the RX trigger in bits 4:2 are retained.
- R9: FIFO status (offset 0x060) reads `tx_free` in bits 7:4 and `rx_fill` in bits 3:0.
- R10: In the default layout the offsets are config 0x000, status 0x068 and divisor 0x06C, plus those above. In the alternate layout, offsets at or above 0x050 are moved up by 0x10 and lower ones by 0x40, so the mask is at 0x074 and config is at 0x040.
- R11: The configuration word and the low 16 bits of the divisor read back as written. A read of an unmapped offset returns 0.
- R12: `reg_rdata` is loaded on the edge where `reg_rd` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| ev_pkt_done | input | 1 | Packet finished pulse |
| ev_all_done | input | 1 | All packets finished pulse |
| ev_nack | input | 1 | Missing acknowledge pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| tx_free | input | CNT_W | Free word slots in the transmit FIFO |
| rx_fill | input | CNT_W | Filled words in the receive FIFO |
| tx_flush | output | 1 | One-cycle transmit FIFO flush request |
| rx_flush | output | 1 | One-cycle receive FIFO flush request |
| irq | output | 1 | Registered interrupt request |

## Verification
Status is driven with all four bus events together and then with partial write-one-to-clear patterns. A clear landing in the same cycle as a new event separates set-priority from clear-priority. The FIFO counts are swept across each trigger level, exactly equal and then one above, to expose an off-by-one in the comparison. This is repeated with a clear written during the held level. Overflow and underflow are probed with the count at zero and at non-zero, which separates the empty-case condition from an unconditional set. A second instance built with the alternate layout is read at the moved offsets while the default instance returns zero there, which tells a correct shift from an unshifted decode.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  localparam int NSTAT = 8;

  localparam int ST_PKT  = 7;
  localparam int ST_ALL  = 6;
  localparam int ST_OVF  = 5;
  localparam int ST_UNF  = 4;
  localparam int ST_NACK = 3;
  localparam int ST_ARB  = 2;
  localparam int ST_TXRQ = 1;
  localparam int ST_RXRQ = 0;

  // base offsets of the default layout
  localparam int OF_CFG   = 'h000;
  localparam int OF_TXF   = 'h050;
  localparam int OF_RXF   = 'h054;
  localparam int OF_FCTL  = 'h05C;
  localparam int OF_FSTAT = 'h060;
  localparam int OF_MASK  = 'h064;
  localparam int OF_STAT  = 'h068;
  localparam int OF_DIV   = 'h06C;

  localparam int SPLIT_OF = 'h050;

  function automatic int map_ofs(input int base, input bit alt);
    if (!alt) return base;
    return base + ((base >= SPLIT_OF) ? 'h10 : 'h40);
  endfunction

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_TXF, SEL_RXF, SEL_FCTL,
    SEL_FSTAT, SEL_MASK, SEL_STAT, SEL_DIV
  } reg_sel_e;

endpackage

// File: rtl/i2cr_addr_dec.sv
module i2cr_addr_dec
  import i2cr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter bit ALT_LAYOUT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(map_ofs(OF_CFG,   ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] A_TXF   = ADDR_W'(map_ofs(OF_TXF,   ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] A_RXF   = ADDR_W'(map_ofs(OF_RXF,   ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] A_FCTL  = ADDR_W'(map_ofs(OF_FCTL,  ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] A_FSTAT = ADDR_W'(map_ofs(OF_FSTAT, ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(map_ofs(OF_MASK,  ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(map_ofs(OF_STAT,  ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(map_ofs(OF_DIV,   ALT_LAYOUT));

  always_comb begin
    sel = SEL_NONE;
    if      (addr == A_CFG)   sel = SEL_CFG;
    else if (addr == A_TXF)   sel = SEL_TXF;
    else if (addr == A_RXF)   sel = SEL_RXF;
    else if (addr == A_FCTL)  sel = SEL_FCTL;
    else if (addr == A_FSTAT) sel = SEL_FSTAT;
    else if (addr == A_MASK)  sel = SEL_MASK;
    else if (addr == A_STAT)  sel = SEL_STAT;
    else if (addr == A_DIV)   sel = SEL_DIV;
  end

endmodule

// File: rtl/i2cr_fifo_ctl.sv
module i2cr_fifo_ctl #(
  parameter int CNT_W  = 4,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fctl,
  input  logic [7:0]        wdata,
  input  logic              wr_txf,
  input  logic              rd_rxf,
  input  logic [CNT_W-1:0]  tx_free,
  input  logic [CNT_W-1:0]  rx_fill,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [TRIG_W-1:0] rx_trig,
  output logic              ovf_set,
  output logic              unf_set,
  output logic              tx_req,
  output logic              rx_req
);

  localparam int PAD_W = CNT_W - TRIG_W;

  // flush bits live for exactly one cycle after the request write
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flush <= 1'b0;
      rx_flush <= 1'b0;
      tx_trig  <= '0;
      rx_trig  <= '0;
    end else begin
      tx_flush <= wr_fctl & wdata[1];
      rx_flush <= wr_fctl & wdata[0];
      if (wr_fctl) begin
        tx_trig <= wdata[7:5];
        rx_trig <= wdata[4:2];
      end
    end
  end

  assign ovf_set = wr_txf && (tx_free == '0);
  assign unf_set = rd_rxf && (rx_fill == '0);
  assign tx_req  = tx_free > {{PAD_W{1'b0}}, tx_trig};
  assign rx_req  = rx_fill > {{PAD_W{1'b0}}, rx_trig};

endmodule

// File: rtl/i2cr_int_ctl.sv
module i2cr_int_ctl #(
  parameter int         NBIT       = 8,
  parameter logic [7:0] LEVEL_BITS = 8'b0000_0011
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_mask,
  input  logic            wr_stat,
  input  logic [NBIT-1:0] wdata,
  input  logic [NBIT-1:0] src,
  output logic [NBIT-1:0] stat_q,
  output logic [NBIT-1:0] mask_q,
  output logic            irq
);

  logic [NBIT-1:0] stat_d;
  logic [NBIT-1:0] mask_d;

  for (genvar b = 0; b < NBIT; b++) begin : g_bit
    if (LEVEL_BITS[b]) begin : g_lvl
      assign stat_d[b] = src[b];
    end else begin : g_stk
      assign stat_d[b] = src[b] | (stat_q[b] & ~(wr_stat & wdata[b]));
    end
  end

  assign mask_d = wr_mask ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq    <= |(stat_d & mask_d);
    end
  end

endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2cr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 4,
  parameter int DIV_W      = 16,
  parameter bit ALT_LAYOUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_pkt_done,
  input  logic              ev_all_done,
  input  logic              ev_nack,
  input  logic              ev_arb_lost,
  input  logic [CNT_W-1:0]  tx_free,
  input  logic [CNT_W-1:0]  rx_fill,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              irq
);

  localparam int TRIG_W = 3;
  localparam logic [7:0] LVL = 8'((1 << ST_TXRQ) | (1 << ST_RXRQ));

  reg_sel_e          sel;
  logic [TRIG_W-1:0] tx_trig;
  logic [TRIG_W-1:0] rx_trig;
  logic              ovf_set, unf_set, tx_req, rx_req;
  logic [NSTAT-1:0]  src;
  logic [NSTAT-1:0]  stat_q;
  logic [NSTAT-1:0]  mask_q;
  logic [DATA_W-1:0] cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rd_mux;

  i2cr_addr_dec #(.ADDR_W(ADDR_W), .ALT_LAYOUT(ALT_LAYOUT)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  i2cr_fifo_ctl #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_fctl  (reg_wr && sel == SEL_FCTL),
    .wdata    (reg_wdata[7:0]),
    .wr_txf   (reg_wr && sel == SEL_TXF),
    .rd_rxf   (reg_rd && sel == SEL_RXF),
    .tx_free  (tx_free),
    .rx_fill  (rx_fill),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush),
    .tx_trig  (tx_trig),
    .rx_trig  (rx_trig),
    .ovf_set  (ovf_set),
    .unf_set  (unf_set),
    .tx_req   (tx_req),
    .rx_req   (rx_req)
  );

  always_comb begin
    src          = '0;
    src[ST_PKT]  = ev_pkt_done;
    src[ST_ALL]  = ev_all_done;
    src[ST_OVF]  = ovf_set;
    src[ST_UNF]  = unf_set;
    src[ST_NACK] = ev_nack;
    src[ST_ARB]  = ev_arb_lost;
    src[ST_TXRQ] = tx_req;
    src[ST_RXRQ] = rx_req;
  end

  i2cr_int_ctl #(.NBIT(NSTAT), .LEVEL_BITS(LVL)) u_int (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (reg_wr && sel == SEL_MASK),
    .wr_stat (reg_wr && sel == SEL_STAT),
    .wdata   (reg_wdata[NSTAT-1:0]),
    .src     (src),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      div_q <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_CFG) cfg_q <= reg_wdata;
      if (sel == SEL_DIV) div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CFG:   rd_mux = cfg_q;
      SEL_FCTL:  rd_mux = DATA_W'({tx_trig, rx_trig, tx_flush, rx_flush});
      SEL_FSTAT: rd_mux = DATA_W'({tx_free, rx_fill});
      SEL_MASK:  rd_mux = DATA_W'(mask_q);
      SEL_STAT:  rd_mux = DATA_W'(stat_q);
      SEL_DIV:   rd_mux = DATA_W'(div_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/i2cr_regs_chk.sv
module i2cr_regs_chk
  import i2cr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CNT_W      = 4,
  parameter bit ALT_LAYOUT = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              ev_pkt_done,
  input logic [CNT_W-1:0]  tx_free,
  input logic [CNT_W-1:0]  rx_fill,
  input logic              tx_flush,
  input logic              irq,
  input logic [7:0]        stat_q,
  input logic [7:0]        mask_q,
  input logic [2:0]        tx_trig
);

  localparam logic [ADDR_W-1:0] C_TXF  = ADDR_W'(map_ofs(OF_TXF,  ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] C_RXF  = ADDR_W'(map_ofs(OF_RXF,  ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] C_FCTL = ADDR_W'(map_ofs(OF_FCTL, ALT_LAYOUT));
  localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'(map_ofs(OF_STAT, ALT_LAYOUT));

  logic [CNT_W-1:0] trig_ext;
  assign trig_ext = CNT_W'(tx_trig);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (stat_q == 8'h00 && mask_q == 8'h00 && !irq && !tx_flush));

  p_w1c_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == C_STAT && reg_wdata[7] && !ev_pkt_done) |=> !stat_q[7]);

  p_overflow_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == C_TXF && tx_free == '0) |=> stat_q[5]);

  p_underflow_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == C_RXF && rx_fill == '0) |=> stat_q[4]);

  p_txreq_level_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (stat_q[1] == ($past(tx_free) > $past(trig_ext))));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((stat_q & mask_q) != 8'h00));

  p_flush_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_flush && !(reg_wr && reg_addr == C_FCTL && reg_wdata[1])) |=> !tx_flush);

endmodule

bind i2c_ctl_regs i2cr_regs_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ALT_LAYOUT(ALT_LAYOUT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata[7:0]),
  .ev_pkt_done (ev_pkt_done),
  .tx_free     (tx_free),
  .rx_fill     (rx_fill),
  .tx_flush    (tx_flush),
  .irq         (irq),
  .stat_q      (stat_q),
  .mask_q      (mask_q),
  .tx_trig     (tx_trig)
);

// File: tb/i2c_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module i2c_ctl_regs_tb_top;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam int CW = 4;
  localparam int WD_CYC = 200000;

  localparam logic [AW-1:0] A_CFG   = 12'h000;
  localparam logic [AW-1:0] A_TXF   = 12'h050;
  localparam logic [AW-1:0] A_RXF   = 12'h054;
  localparam logic [AW-1:0] A_FCTL  = 12'h05C;
  localparam logic [AW-1:0] A_FSTAT = 12'h060;
  localparam logic [AW-1:0] A_MASK  = 12'h064;
  localparam logic [AW-1:0] A_STAT  = 12'h068;
  localparam logic [AW-1:0] A_DIV   = 12'h06C;
  localparam logic [AW-1:0] X_CFG   = 12'h040;
  localparam logic [AW-1:0] X_MASK  = 12'h074;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] rdata, rdata_x;
  logic ev_pkt = 1'b0, ev_all = 1'b0, ev_nack = 1'b0, ev_arb = 1'b0;
  logic [CW-1:0] tx_free = '0, rx_fill = '0;
  logic tx_flush, rx_flush, irq;
  logic tx_flush_x, rx_flush_x, irq_x;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_ctl_regs #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
    .ev_pkt_done(ev_pkt), .ev_all_done(ev_all), .ev_nack(ev_nack),
    .ev_arb_lost(ev_arb), .tx_free(tx_free), .rx_fill(rx_fill),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .irq(irq)
  );

  i2c_ctl_regs #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .ALT_LAYOUT(1'b1)) dut_alt (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_x),
    .ev_pkt_done(ev_pkt), .ev_all_done(ev_all), .ev_nack(ev_nack),
    .ev_arb_lost(ev_arb), .tx_free(tx_free), .rx_fill(rx_fill),
    .tx_flush(tx_flush_x), .rx_flush(rx_flush_x), .irq(irq_x)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(A_STAT, d); chk("R1 status after reset", d, 0);
    rd(A_MASK, d); chk("R1 mask after reset", d, 0);
    rd(A_FCTL, d); chk("R1 fifo control after reset", d, 0);
    rd(A_CFG, d);  chk("R1 config after reset", d, 0);
    chk("R1 irq/flush after reset", {29'd0, irq, tx_flush, rx_flush}, 0);
  endtask

  task automatic t_regs();
    logic [DW-1:0] d;
    wr(A_CFG, 32'hDEAD_BEEF);
    wr(A_DIV, 32'h1234_ABCD);
    rd(A_CFG, d); chk("R11 config readback", d, 32'hDEAD_BEEF);
    // R12: before the read edge the old data is still held
    reg_rd = 1'b1; reg_addr = A_DIV;
    #2; chk("R12 rdata held before edge", rdata, 32'hDEAD_BEEF);
    @(negedge clk); reg_rd = 1'b0;
    chk("R11 divisor low bits readback", rdata, 32'h0000_ABCD);
    idle(2); chk("R12 rdata held without strobe", rdata, 32'h0000_ABCD);
    rd(12'h004, d); chk("R11 unmapped read zero", d, 0);
  endtask

  task automatic t_events();
    logic [DW-1:0] d;
    ev_pkt = 1; ev_all = 1; ev_nack = 1; ev_arb = 1;
    @(negedge clk);
    ev_pkt = 0; ev_all = 0; ev_nack = 0; ev_arb = 0;
    idle(2);
    rd(A_STAT, d); chk("R5 events latched", d, 32'hCC);
    wr(A_STAT, 32'h00);
    rd(A_STAT, d); chk("R2 zero write keeps bits", d, 32'hCC);
    wr(A_STAT, 32'h84);
    rd(A_STAT, d); chk("R2 partial clear", d, 32'h48);
    ev_nack = 1;
    wr(A_STAT, 32'h48);
    ev_nack = 0;
    rd(A_STAT, d); chk("R2 set wins over clear", d, 32'h08);
    wr(A_STAT, 32'h08);
    rd(A_STAT, d); chk("R2 full clear", d, 32'h00);
  endtask

  task automatic t_ovf_unf();
    logic [DW-1:0] d;
    tx_free = 0; rx_fill = 0;
    wr(A_TXF, 32'h1);
    rd(A_STAT, d); chk("R3 overflow on full FIFO write", d & 32'h30, 32'h20);
    wr(A_STAT, 32'h20);
    tx_free = 3;
    wr(A_TXF, 32'h1);
    rd(A_STAT, d); chk("R3 no overflow with free slot", d & 32'h30, 32'h00);
    rd(A_RXF, d);
    rd(A_STAT, d); chk("R4 underflow on empty FIFO read", d & 32'h30, 32'h10);
    wr(A_STAT, 32'h10);
    rx_fill = 2;
    rd(A_RXF, d);
    rd(A_STAT, d); chk("R4 no underflow with data", d & 32'h30, 32'h00);
    tx_free = 0; rx_fill = 0;
    idle(1);
    wr(A_STAT, 32'hFF);
    rd(A_STAT, d); chk("R2 status cleared", d, 0);
  endtask

  task automatic t_irq();
    ev_pkt = 1; @(negedge clk); ev_pkt = 0;
    chk("R7 masked event no irq", {31'd0, irq}, 0);
    wr(A_MASK, 32'h80);
    chk("R7 irq on mask enable", {31'd0, irq}, 1);
    wr(A_STAT, 32'h80);
    chk("R7 irq drops on clear", {31'd0, irq}, 0);
    wr(A_MASK, 32'h02);
    tx_free = 1;
    @(negedge clk);
    chk("R7 irq from level request", {31'd0, irq}, 1);
    tx_free = 0;
    @(negedge clk);
    chk("R7 irq drops with level", {31'd0, irq}, 0);
    wr(A_MASK, 32'h00);
  endtask

  task automatic t_req();
    logic [DW-1:0] d;
    wr(A_FCTL, 32'h64);   // TX trigger 3, RX trigger 1
    tx_free = 3; rx_fill = 1; idle(1);
    rd(A_STAT, d); chk("R6 requests idle at trigger", d & 32'h03, 32'h00);
    tx_free = 4; rx_fill = 2; idle(1);
    rd(A_STAT, d); chk("R6 requests above trigger", d & 32'h03, 32'h03);
    wr(A_STAT, 32'h03);
    rd(A_STAT, d); chk("R6 clear ignored while held", d & 32'h03, 32'h03);
    tx_free = 0; rx_fill = 0; idle(1);
    rd(A_STAT, d); chk("R6 requests drop", d, 32'h00);
  endtask

  task automatic t_flush();
    logic [DW-1:0] d;
    wr(A_FCTL, 32'hE3);
    chk("R8 flush outputs asserted", {30'd0, tx_flush, rx_flush}, 32'h3);
    rd(A_FCTL, d); chk("R8 flush bits read as pending", d, 32'hE3);
    chk("R8 flush outputs one cycle", {30'd0, tx_flush, rx_flush}, 32'h0);
    rd(A_FCTL, d); chk("R8 flush self-cleared, trigger kept", d, 32'hE0);
  endtask

  task automatic t_fstat();
    logic [DW-1:0] d;
    tx_free = 9; rx_fill = 5;
    rd(A_FSTAT, d); chk("R9 FIFO status fields", d, 32'h95);
    tx_free = 0; rx_fill = 0;
    idle(1);
  endtask

  task automatic t_alt();
    logic [DW-1:0] d;
    wr(X_MASK, 32'h5A);
    rd(X_MASK, d);
    chk("R10 alternate mask offset", rdata_x, 32'h5A);
    chk("R10 default layout unmapped there", d, 32'h0);
    wr(X_CFG, 32'hCAFE_0001);
    rd(X_CFG, d);
    chk("R10 alternate config offset", rdata_x, 32'hCAFE_0001);
    rd(A_MASK, d);
    chk("R10 default mask untouched", d, 32'h0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(WD_CYC * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regs();
    t_events();
    t_ovf_unf();
    t_irq();
    t_req();
    t_flush();
    t_fstat();
    t_alt();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule